// File: doc/BRIEF.md
# Bit-Serial Variable-Node Processor for Min-Sum LDPC Decoding

This block is one variable node of a fully parallel min-sum LDPC decoder in which messages travel one bit per clock. Every message word lasts `W` cycles. In that time the node receives one intrinsic channel value and `DV` check-to-variable messages, each least significant bit first in two's complement. For every edge it forms the extrinsic sum: the intrinsic value plus every incoming check message except the one on that edge. It forms this sum with serial adders that keep their carries from cycle to cycle. The wide result is completed in the last bit cycle, clipped to the symmetric message range, and loaded into a conversion register. That register sends it back to the check nodes most significant bit first in sign-magnitude form.

The node runs a further serial adder over all `DV+1` inputs. Its sign is the hard decision for the bit. A surrounding decoder deasserts `en` when it detects convergence, and the node then freezes. The decision register therefore keeps the value of the last active iteration. A `word_start` strobe marks the least significant bit of a word and realigns the node's internal bit counter.

Top module: `vn_bitserial_node`

## Requirements
- R1: At the end of each word, edge i's output value is the intrinsic value plus the sum of all check inputs except check input i, computed without overflow before clipping.
- R2: Inputs are W-bit two's complement words sent least significant bit first, one bit per enabled cycle. Bit 0 arrives in the cycle where `word_start` is 1, or in the enabled cycle after a word's bit W-1.
- R3: The cycle after the enabled cycle carrying input bit W-1, `out_first` is 1 and each `ext_bits[i]` carries the sign bit (1 = negative) of the new output word. The next W-1 enabled cycles carry the magnitude, most significant bit first. `out_first` is 0 in those cycles.
- R4: An output value above 2^(W-1)-1 is sent as sign 0 with the maximum magnitude. A value below -(2^(W-1)-1), including -2^(W-1), is sent as sign 1 with the maximum magnitude.
- R5: An output value of zero is sent as all-zero bits (sign 0, magnitude 0).
- R6: `hard_bit` changes only when `out_first` rises with a new word. It is 1 when the total of the intrinsic value and all check inputs is negative, and 0 when that total is zero or positive.
- R7: In a cycle with `en` = 0 no state advances: outputs hold, input bits are ignored, and the word resumes at the same bit position when `en` returns.
- R8: While `rst` is 1 and after it, until new output is loaded, `ext_bits`, `out_first` and `hard_bit` are all 0.
- R9: Asserting `word_start` in the middle of a word discards the partial word and starts a new one at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Node enable; 0 freezes all state |
| word_start | input | 1 | Marks bit 0 of an input word |
| intr_bit | input | 1 | Serial intrinsic channel value, LSB first |
| chk_bits | input | DV | Serial check-to-variable messages, LSB first |
| ext_bits | output | DV | Serial variable-to-check messages, sign-magnitude, MSB first |
| out_first | output | 1 | High while `ext_bits` carries the sign bit |
| hard_bit | output | 1 | Hard decision of the latest active word |

## Verification
A carry left over from the previous word, or a bit counter that has lost alignment, shows up at the very next sign bit. Each word's output bits come from the exact sum of that word, so a corrupted carry or a shifted bit gives a wrong sign or magnitude within W cycles. A conversion register that shifts while disabled, or loads at the wrong phase, moves `out_first` and the magnitude bits one cycle early or late, and the per-cycle comparison catches that. Saturation errors show only on extreme inputs, so all-maximum and all-minimum words are sent on purpose. Decision errors show only when the total is near zero, so totals of exactly 0 and -1 are sent on purpose.

// File: rtl/vn_pkg.sv
package vn_pkg;

    localparam int unsigned VN_DEG   = 4;
    localparam int unsigned VN_MSG_W = 4;

    // Per-cycle control derived from the bit counter
    typedef struct packed {
        logic first;   // bit 0 of a word
        logic last;    // bit W-1 of a word
        logic run;     // node enabled this cycle
    } vn_slot_t;

    // Carry register width for a serial adder of n_ops operands
    function automatic int unsigned carry_w(input int unsigned n_ops);
        return $clog2(2 * n_ops);
    endfunction

    // Signed width that holds the exact sum of n_ops words of w bits
    function automatic int unsigned sum_w(input int unsigned w, input int unsigned n_ops);
        return w + $clog2(n_ops + 1) + 1;
    endfunction

endpackage

// File: rtl/vn_serial_sum.sv
module vn_serial_sum #(
    parameter int unsigned N = 5,
    parameter int unsigned W = 4,
    localparam int unsigned CW  = vn_pkg::carry_w(N),
    localparam int unsigned CW1 = CW + 1,
    localparam int unsigned NSW = $clog2(N + 1),
    localparam int unsigned SW  = vn_pkg::sum_w(W, N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 first,
    input  logic [N-1:0]         bits,
    output logic signed [SW-1:0] value
);

    logic [CW-1:0]  carry_q;
    logic [CW-1:0]  carry_in;
    logic [CW:0]    col;
    logic [W-2:0]   low_q;
    logic [NSW-1:0] n_neg;
    logic signed [SW-1:0] lo_s;
    logic signed [SW-1:0] hi_s;

    // Column sum of this bit position plus carry from lower bits
    always_comb begin
        carry_in = first ? '0 : carry_q;
        col      = {1'b0, carry_in};
        for (int k = 0; k < N; k++) begin
            col = col + CW1'(bits[k]);
        end
    end

    // Completion in the last cycle: unsigned low bits + 2^W*(carry - signs)
    always_comb begin
        n_neg = NSW'($countones(bits));
        lo_s  = SW'({col[0], low_q});
        hi_s  = SW'(col[CW:1]) - SW'(n_neg);
        value = lo_s + (hi_s <<< W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= '0;
            low_q   <= '0;
        end else if (run) begin
            carry_q <= col[CW:1];
            low_q   <= (low_q >> 1) | ((W-1)'(col[0]) << (W - 2));
        end
    end

endmodule

// File: rtl/vn_sm_serializer.sv
module vn_sm_serializer #(
    parameter int unsigned W  = 4,
    parameter int unsigned SW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 load,
    input  logic signed [SW-1:0] value,
    output logic                 ser
);

    localparam logic signed [SW-1:0] POS_LIM = SW'((1 << (W - 1)) - 1);
    localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM;

    logic [W-1:0] code;
    logic [W-1:0] sr_q;

    // Clip to the symmetric range, then sign-magnitude
    always_comb begin
        if (value > POS_LIM)
            code = {1'b0, POS_LIM[W-2:0]};
        else if (value < NEG_LIM)
            code = {1'b1, POS_LIM[W-2:0]};
        else if (value < 0)
            code = {1'b1, (W-1)'(-value)};
        else
            code = {1'b0, (W-1)'(value)};
    end

    // Conversion register: parallel load, MSB-first shift out
    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (run)
            sr_q <= load ? code : (sr_q << 1);
    end

    assign ser = sr_q[W-1];

endmodule

// File: rtl/vn_bitserial_node.sv
module vn_bitserial_node #(
    parameter int unsigned DV = vn_pkg::VN_DEG,
    parameter int unsigned W  = vn_pkg::VN_MSG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          word_start,
    input  logic          intr_bit,
    input  logic [DV-1:0] chk_bits,
    output logic [DV-1:0] ext_bits,
    output logic          out_first,
    output logic          hard_bit
);

    localparam int unsigned PW   = (W > 2) ? $clog2(W) : 1;
    localparam int unsigned SW_E = vn_pkg::sum_w(W, DV);
    localparam int unsigned SW_T = vn_pkg::sum_w(W, DV + 1);

    vn_pkg::vn_slot_t slot;
    logic [PW-1:0]    ph_q;
    logic [PW-1:0]    idx;

    // Bit position of the current input bit
    always_comb begin
        idx        = word_start ? '0 : ph_q;
        slot.first = (idx == '0);
        slot.last  = (idx == PW'(W - 1));
        slot.run   = en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (slot.run)
            ph_q <= slot.last ? '0 : idx + 1'b1;
    end

    // One extrinsic adder and one converter per edge
    for (genvar i = 0; i < DV; i++) begin : g_edge
        logic [DV-1:0]          ops;
        logic signed [SW_E-1:0] sum_v;

        // operand set: all checks, with edge i's own input swapped for the intrinsic
        always_comb begin
            ops    = chk_bits;
            ops[i] = intr_bit;
        end

        vn_serial_sum #(.N(DV), .W(W)) i_sum (
            .clk   (clk),
            .rst   (rst),
            .run   (slot.run),
            .first (slot.first),
            .bits  (ops),
            .value (sum_v)
        );

        vn_sm_serializer #(.W(W), .SW(SW_E)) i_ser (
            .clk   (clk),
            .rst   (rst),
            .run   (slot.run),
            .load  (slot.last),
            .value (sum_v),
            .ser   (ext_bits[i])
        );
    end

    // Total over every input for the hard decision
    logic signed [SW_T-1:0] total_v;
    logic                   unused_total_low;

    vn_serial_sum #(.N(DV + 1), .W(W)) i_total (
        .clk   (clk),
        .rst   (rst),
        .run   (slot.run),
        .first (slot.first),
        .bits  ({intr_bit, chk_bits}),
        .value (total_v)
    );

    assign unused_total_low = ^total_v[SW_T-2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_first <= 1'b0;
            hard_bit  <= 1'b0;
        end else if (slot.run) begin
            out_first <= slot.last;
            if (slot.last)
                hard_bit <= total_v[SW_T-1];
        end
    end

endmodule

// File: rtl/vn_node_chk.sv
module vn_node_chk #(
    parameter int unsigned DV = 4,
    parameter int unsigned W  = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [DV-1:0] ext_bits,
    input logic          out_first,
    input logic          hard_bit
);

    // R7
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(ext_bits) && $stable(out_first) && $stable(hard_bit)));

    // R3
    sign_slot_once_chk: assert property (@(posedge clk) disable iff (rst)
        (out_first && en) |=> !out_first);

    // R6
    decision_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(hard_bit) |-> $rose(out_first));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ext_bits == '0 && !out_first && !hard_bit));

endmodule

bind vn_bitserial_node vn_node_chk #(.DV(DV), .W(W)) i_vn_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .ext_bits  (ext_bits),
    .out_first (out_first),
    .hard_bit  (hard_bit)
);

// File: tb/test_vn_bitserial_node.sv
module test_vn_bitserial_node;

    localparam int DV  = 4;
    localparam int W   = 4;
    localparam int LIM = (1 << (W - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic          word_start;
    logic          intr_bit;
    logic [DV-1:0] chk_bits;
    logic [DV-1:0] ext_bits;
    logic          out_first;
    logic          hard_bit;

    always #2 clk = ~clk;

    vn_bitserial_node #(.DV(DV), .W(W)) i_vn_bitserial_node (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .word_start (word_start),
        .intr_bit   (intr_bit),
        .chk_bits   (chk_bits),
        .ext_bits   (ext_bits),
        .out_first  (out_first),
        .hard_bit   (hard_bit)
    );

    int total_n = 0;
    int bad_n   = 0;
    bit done    = 1'b0;

    // Behavioural model state
    int m_ph;
    int m_raw[DV+1];
    int m_code[DV];
    int m_pos;
    bit m_first;
    bit m_dec;

    function automatic int to_signed(input int raw);
        return (raw >= (1 << (W - 1))) ? raw - (1 << W) : raw;
    endfunction

    function automatic int to_code(input int v);
        int mag;
        mag = (v < 0) ? -v : v;
        if (mag > LIM) mag = LIM;
        return (v < 0) ? ((1 << (W - 1)) | mag) : mag;
    endfunction

    task automatic model_step(input bit e, input bit ws, input bit ib, input logic [DV-1:0] cb);
        int idx;
        int vals[DV+1];
        int tot;
        if (!e) return;
        idx = ws ? 0 : m_ph;
        for (int j = 0; j <= DV; j++) begin
            int b;
            b = (j == DV) ? int'(ib) : int'(cb[j]);
            m_raw[j] = ((idx == 0) ? 0 : m_raw[j]) | (b << idx);
        end
        if (idx == W - 1) begin
            tot = 0;
            for (int j = 0; j <= DV; j++) begin
                vals[j] = to_signed(m_raw[j]);
                tot += vals[j];
            end
            for (int i = 0; i < DV; i++) m_code[i] = to_code(tot - vals[i]);
            m_pos   = 0;
            m_first = 1'b1;
            m_dec   = (tot < 0);
            m_ph    = 0;
        end else begin
            if (m_pos < W) m_pos++;
            m_first = 1'b0;
            m_ph    = idx + 1;
        end
    endtask

    task automatic check_outs(input string tag);
        for (int i = 0; i < DV; i++) begin
            bit exp_b;
            exp_b = (m_pos < W) ? 1'((m_code[i] >> (W - 1 - m_pos)) & 1) : 1'b0;
            total_n++;
            if (ext_bits[i] !== exp_b) begin
                bad_n++;
                $display("FAIL %s ext_bits[%0d] got %0b exp %0b at %0t", tag, i, ext_bits[i], exp_b, $time);
            end
        end
        total_n++;
        if (out_first !== m_first) begin
            bad_n++;
            $display("FAIL %s R3 out_first got %0b exp %0b at %0t", tag, out_first, m_first, $time);
        end
        total_n++;
        if (hard_bit !== m_dec) begin
            bad_n++;
            $display("FAIL %s R6 hard_bit got %0b exp %0b at %0t", tag, hard_bit, m_dec, $time);
        end
    endtask

    // Drive at negedge, model after posedge, compare at next negedge
    task automatic step(input bit e, input bit ws, input bit ib, input logic [DV-1:0] cb, input string tag);
        en = e; word_start = ws; intr_bit = ib; chk_bits = cb;
        @(posedge clk);
        model_step(e, ws, ib, cb);
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic send_word(input int c[DV], input int ci, input int gap_at, input int gap_len,
                             input bit ws0, input string tag);
        for (int k = 0; k < W; k++) begin
            logic [DV-1:0] cb;
            if (k == gap_at) begin
                for (int g = 0; g < gap_len; g++)
                    step(1'b0, 1'b0, 1'($urandom), DV'($urandom), {tag, " R7"});
            end
            for (int i = 0; i < DV; i++) cb[i] = 1'((c[i] >> k) & 1);
            step(1'b1, ws0 && (k == 0), 1'((ci >> k) & 1), cb, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad_n++;
            $display("FAIL watchdog expired got running exp finished");
            $display("test done: total=%0d bad=%0d", total_n, bad_n);
            $finish;
        end
    end

    initial begin
        m_ph = 0; m_pos = W; m_first = 0; m_dec = 0;
        for (int j = 0; j <= DV; j++) m_raw[j] = 0;
        for (int i = 0; i < DV; i++) m_code[i] = 0;
        rst = 1'b1; en = 1'b1; word_start = 1'b0; intr_bit = 1'b1; chk_bits = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, '0, "R8 reset state");

        // R1 R2 R3 basic words, back to back
        send_word('{1, 2, 3, -1}, 2, -1, 0, 1'b1, "R1 R2 R3 mixed");
        send_word('{-2, 0, 5, 1}, -3, -1, 0, 1'b0, "R1 R2 R3 wrap start");
        // R4 saturation both ways
        send_word('{7, 7, 7, 7}, 7, -1, 0, 1'b1, "R4 positive clip");
        send_word('{-8, -8, -8, -8}, -8, -1, 0, 1'b1, "R4 negative clip");
        send_word('{-8, 0, 0, 0}, 0, -1, 0, 1'b1, "R4 minus eight");
        // R5 zero and cancellation
        send_word('{0, 0, 0, 0}, 0, -1, 0, 1'b1, "R5 zero");
        send_word('{3, -3, 2, -2}, 0, -1, 0, 1'b1, "R5 cancel");
        // R6 decision near zero
        send_word('{0, 0, 0, -1}, 0, -1, 0, 1'b1, "R6 total minus one");
        send_word('{1, 0, 0, -1}, 0, -1, 0, 1'b1, "R6 total zero");
        // R7 enable gaps mid word and at start
        send_word('{4, -5, 6, -7}, 1, 2, 3, 1'b1, "R7 gap mid");
        send_word('{-1, -1, 2, 2}, -4, 0, 2, 1'b1, "R7 gap first");
        // R9 abort partial word
        step(1'b1, 1'b1, 1'b1, '1, "R9 partial");
        step(1'b1, 1'b0, 1'b1, '1, "R9 partial");
        send_word('{2, 2, 2, 2}, -6, -1, 0, 1'b1, "R9 restart");
        // Random traffic
        for (int n = 0; n < 300; n++) begin
            int c[DV];
            for (int i = 0; i < DV; i++) c[i] = int'($urandom_range(0, 15)) - 8;
            send_word(c, int'($urandom_range(0, 15)) - 8,
                      ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, W - 1)) : -1,
                      int'($urandom_range(1, 3)), 1'($urandom), "R1 R4 R6 random");
        end
        for (int k = 0; k < W + 1; k++) step(1'b1, 1'b0, 1'b0, '0, "R3 flush");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

endmodule